// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block takes a gain-setting word over a three-wire serial port: a serial clock, a data line and an active-low load enable. The three lines are oversampled by a faster system clock through two-flop synchronisers, and rising serial clock edges are found on the synchronised copy. While the load enable is low, each rising serial clock edge shifts one data bit into a 7-bit register, most significant bit first. A word is 8 bits long, so the first bit sent falls off the end. When the load enable rises, the register contents are copied into an output latch. That latch drives the attenuator control bus.

Two asynchronous mode inputs, transmit enable and awake, are synchronised and decoded into a 2-bit power state. A transmit-ready flag is raised only once a complete word has been latched and the power state is active. A bit counter reports how many bits arrived in the current load window. A sticky flag records any window that closed with a count other than eight.

The system clock must run at least four times faster than the serial clock.

Top module: `gain_word_rx`

## Requirements
- R1: After reset, the gain code is 0, the word-valid, malformed and transmit-ready flags are 0, the bit count is 0, and the power state is SLEEP (2'b00).
- R2: While the load enable is high, serial clock edges shift no bits and do not change the bit count.
- R3: With the load enable low, each rising serial clock edge samples the data line, most significant bit first. After an 8-bit word, the latched code equals the last 7 bits sent, so words 128 to 255 give the same code as words 0 to 127.
- R4: The gain code stays at its previous value during a load window. It changes only when the load enable rises.
- R5: The bit count is cleared when the load enable falls and rises by one for each bit shifted. It saturates at 15.
- R6: If the load enable rises after a count other than 8, the malformed flag is set and stays set until reset. The register contents are still latched.
- R7: The power state is SLEEP (2'b00) when awake is low, whatever transmit enable is. It is DISABLED (2'b01) when awake is high and transmit enable is low. It is ACTIVE (2'b10) when both are high.
- R8: The word-valid flag is set by the first latch and stays set. Transmit-ready is high exactly when word-valid is set and the power state is ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data, MSB first |
| load_ni | input | 1 | Active-low load enable |
| txen_i | input | 1 | Transmit enable (1 = on) |
| awake_i | input | 1 | Awake (0 = sleep) |
| gain_code_o | output | 7 | Latched attenuator code |
| bit_count_o | output | 4 | Bits received in current window |
| malformed_o | output | 1 | Sticky: a window closed with count other than 8 |
| word_valid_o | output | 1 | At least one word latched |
| power_state_o | output | 2 | 00 sleep, 01 disabled, 10 active |
| tx_ready_o | output | 1 | Word valid and power state active |

## Verification
Eight-bit words are sent with the leading bit both set and clear. This shows whether the first bit is dropped, and all-zero, all-one and alternating words expose bit order and shift direction. Other windows use the wrong number of bits:
- Windows of zero, five and twenty bits check that malformed windows are flagged but still latched, and that the counter saturates.
- Serial clock pulses with the enable high check that shifting is blocked.

A mid-window probe separates the register from the latch. All four combinations of the mode inputs, tried before and after the first word, separate the power decode from the transmit-ready gating.

// File: rtl/gwrx_pkg.sv
package gwrx_pkg;
  typedef enum logic [1:0] {
    PWR_SLEEP  = 2'b00,
    PWR_OFF    = 2'b01,
    PWR_ACTIVE = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/gwrx_sync.sv
module gwrx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gwrx_shifter.sv
module gwrx_shifter #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  input  logic              load_n_s_i,
  output logic [CODE_W-1:0] shreg_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              load_rise_o
);
  logic sclk_q, load_q;
  logic sclk_rise, load_fall, shift_en;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      load_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      load_q <= load_n_s_i;
    end

  assign sclk_rise   = sclk_s_i & ~sclk_q;
  assign load_rise_o = load_n_s_i & ~load_q;
  assign load_fall   = ~load_n_s_i & load_q;
  assign shift_en    = sclk_rise & ~load_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       shreg_o <= '0;
    else if (shift_en) shreg_o <= {shreg_o[CODE_W-2:0], sdata_s_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        count_o <= '0;
    else if (load_fall)                 count_o <= shift_en ? CNT_W'(1) : '0;
    else if (shift_en && count_o != '1) count_o <= count_o + 1'b1;

  assert_shift_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_n_s_i |=> $stable(shreg_o));
  assert_count_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_s_i && load_q) |=> $stable(count_o));
endmodule

// File: rtl/gwrx_latch.sv
module gwrx_latch #(
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned WORD_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_rise_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CODE_W-1:0] shreg_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              malformed_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_o      <= '0;
      valid_o     <= 1'b0;
      malformed_o <= 1'b0;
    end else if (load_rise_i) begin
      code_o  <= shreg_i;
      valid_o <= 1'b1;
      if (count_i != CNT_W'(WORD_BITS)) malformed_o <= 1'b1;
    end

  assert_code_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_rise_i |=> $stable(code_o));
  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  assert_malformed_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    malformed_o |=> malformed_o);
endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx
  import gwrx_pkg::*;
#(
  parameter int unsigned CODE_W      = 7,
  parameter int unsigned WORD_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(2 * WORD_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              load_ni,
  input  logic              txen_i,
  input  logic              awake_i,
  output logic [CODE_W-1:0] gain_code_o,
  output logic [CNT_W-1:0]  bit_count_o,
  output logic              malformed_o,
  output logic              word_valid_o,
  output logic [1:0]        power_state_o,
  output logic              tx_ready_o
);
  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw, syn;
  logic [CODE_W-1:0] shreg;
  logic load_rise;
  pwr_state_e pstate;

  assign raw = {awake_i, txen_i, load_ni, sdata_i, sclk_i};

  // load enable resets high so reset release makes no false edge
  gwrx_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(5'b00100)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  gwrx_shifter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni,
    .sclk_s_i(syn[0]), .sdata_s_i(syn[1]), .load_n_s_i(syn[2]),
    .shreg_o(shreg), .count_o(bit_count_o), .load_rise_o(load_rise)
  );

  gwrx_latch #(.CODE_W(CODE_W), .CNT_W(CNT_W), .WORD_BITS(WORD_BITS)) u_latch (
    .clk_i, .rst_ni,
    .load_rise_i(load_rise), .count_i(bit_count_o), .shreg_i(shreg),
    .code_o(gain_code_o), .valid_o(word_valid_o), .malformed_o(malformed_o)
  );

  always_comb begin
    if (!syn[4])      pstate = PWR_SLEEP;
    else if (!syn[3]) pstate = PWR_OFF;
    else              pstate = PWR_ACTIVE;
  end

  assign power_state_o = pstate;
  assign tx_ready_o    = word_valid_o && (pstate == PWR_ACTIVE);

  assert_tx_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (word_valid_o && power_state_o == 2'b10));
  assert_count_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(syn[2]) |=> (bit_count_o <= CNT_W'(1)));
endmodule

// File: tb/gain_word_rx_tb_top.sv
module gain_word_rx_tb_top;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, load_n = 1, txen = 0, awake = 0;
  logic [6:0] gain_code;
  logic [3:0] bit_count;
  logic malformed, word_valid, tx_ready;
  logic [1:0] pstate;

  int n_chk = 0, n_fail = 0;

  typedef struct { logic [6:0] code; logic mal; } exp_t;
  exp_t q[$];
  event word_done;
  logic [6:0] m_reg = '0;
  logic       m_mal = 0;

  always #10 clk = ~clk;

  gain_word_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .load_ni(load_n),
    .txen_i(txen), .awake_i(awake), .gain_code_o(gain_code), .bit_count_o(bit_count),
    .malformed_o(malformed), .word_valid_o(word_valid), .power_state_o(pstate),
    .tx_ready_o(tx_ready)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_window();
    load_n = 0;
    wait_cyc(4);
  endtask

  task automatic clock_bit(logic b);
    sdata = b;
    wait_cyc(4);
    sclk = 1;
    wait_cyc(4);
    sclk = 0;
    m_reg = {m_reg[5:0], b};
  endtask

  task automatic close_window(int nbits);
    exp_t e;
    load_n = 1;
    if (nbits != 8) m_mal = 1;
    e.code = m_reg; e.mal = m_mal;
    q.push_back(e);
    wait_cyc(8);
    ->word_done;
    wait_cyc(1);
  endtask

  task automatic send(int n, logic [31:0] v);
    open_window();
    for (int i = n - 1; i >= 0; i--) clock_bit(v[i]);
    wait_cyc(2);
    close_window(n);
  endtask

  // monitor: compare latched results against queued expectations
  initial begin
    forever begin
      @(word_done);
      if (q.size() == 0) chk("R3 queue", 0, 1);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R3/R6 code", gain_code, e.code);
        chk("R6 malformed", malformed, e.mal);
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk("watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1 code", gain_code, 0);
    chk("R1 valid", word_valid, 0);
    chk("R1 malformed", malformed, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 count", bit_count, 0);
    chk("R1 state", pstate, 0);
    rst_n = 1;
    wait_cyc(2);

    awake = 1; txen = 1;
    wait_cyc(5);
    chk("R7 active", pstate, 2);
    chk("R8 no word yet", tx_ready, 0);

    send(8, 32'h47);
    chk("R8 valid", word_valid, 1);
    chk("R8 tx_ready", tx_ready, 1);

    // mid-window probe, word 0xD5 -> 0x55
    open_window();
    clock_bit(1); clock_bit(1); clock_bit(0);
    wait_cyc(6);
    chk("R5 count mid", bit_count, 3);
    chk("R4 hold", gain_code, 7'h47);
    clock_bit(1); clock_bit(0); clock_bit(1); clock_bit(0); clock_bit(1);
    wait_cyc(2);
    close_window(8);
    chk("R3 msb dropped", gain_code, 7'h55);

    send(8, 32'h00);
    send(8, 32'hFF);
    send(8, 32'hAA);
    chk("R3 alternating", gain_code, 7'h2A);

    // clocks with enable high must shift nothing
    sdata = 1;
    for (int i = 0; i < 3; i++) begin
      wait_cyc(4); sclk = 1; wait_cyc(4); sclk = 0;
    end
    wait_cyc(6);
    chk("R2 count frozen", bit_count, 8);
    chk("R2 code kept", gain_code, 7'h2A);
    open_window();
    wait_cyc(4);
    chk("R5 cleared on fall", bit_count, 0);
    close_window(0);
    chk("R2 register untouched", gain_code, 7'h2A);

    send(5, 32'h16);
    chk("R6 short latched", gain_code, 7'h56);
    send(8, 32'h33);
    chk("R6 sticky", malformed, 1);

    open_window();
    for (int i = 0; i < 20; i++) clock_bit(1);
    wait_cyc(6);
    chk("R5 saturate", bit_count, 15);
    close_window(20);

    awake = 0; txen = 1;
    wait_cyc(5);
    chk("R7 sleep", pstate, 0);
    chk("R8 sleep gate", tx_ready, 0);
    awake = 1; txen = 0;
    wait_cyc(5);
    chk("R7 disabled", pstate, 1);
    chk("R8 disabled gate", tx_ready, 0);
    awake = 0; txen = 0;
    wait_cyc(5);
    chk("R7 sleep both low", pstate, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule